// File: doc/BRIEF.md
# Randomized-Leaf Tree Pseudo-LRU Victim Selector

This block chooses which way of a 16-way set-associative cache to evict on a miss. For each set it stores the upper levels of a binary pseudo-LRU decision tree. The upper levels are the root, the two second-level nodes and the four third-level nodes, which makes seven bits per set. The bottom level of the tree picks one way out of a pair of sibling ways. That level is not stored. A bit drawn from a pseudo-random generator takes its place, so within the pair the choice is a coin flip.

The cache controller presents one access per cycle on a plain strobe interface: a set index, a valid strobe, a hit flag and, on a hit, the way that hit. On a miss, the victim way comes out combinationally in the same cycle. The tree of the addressed set is then updated on the next clock edge, so that it points away from the way just touched: the hit way on a hit, or the victim on a miss. The strobe carries no back-pressure: every access with the valid strobe high is consumed in its own cycle. The number of sets is a parameter. The target organisation has 4096 sets, and the default is smaller for simulation.

Top module: `rpl_victim_sel`

## Requirements
- R1: After reset every stored tree bit of every set is 0, so the first miss to any set picks a way of pair 0 (way 0 or way 1).
- R2: `victim_valid` is 1 in exactly those cycles where `acc_valid` is 1 and `acc_hit` is 0.
- R3: The victim way is formed as follows. Bits [3:1] are the pair found by walking the stored tree from the root, where a node value of 0 selects the lower-numbered half and 1 selects the upper half. Bit [0] is the pseudo-random bit. `victim_way` shows this candidate in every cycle, and `victim_valid` qualifies it.
- R4: Starting from reset with no hits, consecutive misses to one set visit the pairs 0, 4, 2, 6, 1, 5, 3, 7 in that order. The sequence then repeats, so every 8 misses the tree points at the same subtree again.
- R5: Any access sets each stored node on the path to the accessed way so that it points away from that way. After reset, a hit to way w followed by a miss in the same set therefore yields pair {~w[3], 0, 0}.
- R6: The tree state of each set is independent. Accesses to one set do not change the victims chosen in another set.
- R7: The random bit comes from a 16-bit maximal-length LFSR with a non-zero seed loaded at reset. It advances once per miss, and over 256 consecutive misses each bit value appears at least 64 times.
- R8: In a cycle with `acc_valid` low, no state changes. The candidate pair for a set stays the same across idle cycles.
- R9: The tree update caused by an access takes effect at the clock edge that ends the access cycle. It is visible to an access to the same set in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, one access per cycle |
| acc_set | input | SET_W | Set index of the access |
| acc_hit | input | 1 | 1 = hit, 0 = miss |
| acc_way | input | WAY_W | Way that hit, used only when acc_hit is 1 |
| victim_valid | output | 1 | A miss is being served this cycle |
| victim_way | output | WAY_W | Way to evict (candidate shown in every cycle) |

## Verification
The hardest thing to show from the ports is the behaviour of the leaf level. It has no stored state, so the only visible trace of the LFSR is the low bit of `victim_way`. The stimulus drives 256 back-to-back misses into one set. It scores the pair bits against the expected 8-step cycle, and it tallies the random bit to check both values appear in balance. Tree updates from hits are made visible by hitting a freshly reset set and then missing in it. Set independence is shown by interleaving misses across sets, each scored against its own sequence.

// File: rtl/rpl_pkg.sv
package rpl_pkg;
  localparam int LFSR_W = 16;
  // x^16 + x^14 + x^13 + x^11 + 1, right-shifting Galois form
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] sh;
    sh = s >> 1;
    return s[0] ? (sh ^ LFSR_TAPS) : sh;
  endfunction
endpackage

// File: rtl/rpl_lfsr.sv
module rpl_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic rnd
);
  import rpl_pkg::*;
  localparam logic [LFSR_W-1:0] SEED_NZ = (SEED == '0) ? 16'h0001 : SEED;

  logic [LFSR_W-1:0] state;

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= SEED_NZ;
    else if (step) state <= lfsr_next(state);
  end

  assign rnd = state[0];
endmodule

// File: rtl/rpl_tree_store.sv
module rpl_tree_store #(
  parameter int NUM_SETS = 16,
  parameter int NODES    = 7,
  localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_idx,
  input  logic             wr_en,
  input  logic [NODES-1:0] wr_tree,
  output logic [NODES-1:0] rd_tree
);
  logic [NODES-1:0] mem [NUM_SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) mem[s] <= '0;
    end else if (wr_en) begin
      mem[set_idx] <= wr_tree;
    end
  end

  assign rd_tree = mem[set_idx];
endmodule

// File: rtl/rpl_path_pick.sv
// Walks the stored levels from the root; needs NUM_WAYS >= 8.
module rpl_path_pick #(
  parameter int NUM_WAYS = 16,
  localparam int PAIRS   = NUM_WAYS / 2,
  localparam int PAIR_W  = $clog2(PAIRS),
  localparam int NODES   = PAIRS - 1
) (
  input  logic [NODES-1:0]  tree,
  output logic [PAIR_W-1:0] pair
);
  logic [PAIR_W-1:0] idx;
  logic              dir;

  always_comb begin
    idx  = '0;
    dir  = 1'b0;
    pair = '0;
    for (int l = 0; l < PAIR_W; l++) begin
      dir = tree[idx];
      pair[PAIR_W-1-l] = dir;
      idx = {idx[PAIR_W-2:0], 1'b0} + {{(PAIR_W-1){1'b0}}, 1'b1}
            + {{(PAIR_W-1){1'b0}}, dir};
    end
  end
endmodule

// File: rtl/rpl_tree_update.sv
// Points every stored node on the path to 'way' away from it.
module rpl_tree_update #(
  parameter int NUM_WAYS = 16,
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int PAIRS   = NUM_WAYS / 2,
  localparam int PAIR_W  = $clog2(PAIRS),
  localparam int NODES   = PAIRS - 1
) (
  input  logic [NODES-1:0] tree,
  input  logic [WAY_W-1:0] way,
  output logic [NODES-1:0] tree_next
);
  logic [PAIR_W-1:0] idx;
  logic              b;

  always_comb begin
    tree_next = tree;
    idx = '0;
    b   = 1'b0;
    for (int l = 0; l < PAIR_W; l++) begin
      b = way[WAY_W-1-l];
      tree_next[idx] = ~b;
      idx = {idx[PAIR_W-2:0], 1'b0} + {{(PAIR_W-1){1'b0}}, 1'b1}
            + {{(PAIR_W-1){1'b0}}, b};
    end
  end
endmodule

// File: rtl/rpl_victim_sel.sv
module rpl_victim_sel #(
  parameter int          NUM_SETS  = 16,
  parameter int          NUM_WAYS  = 16,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  localparam int SET_W  = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int WAY_W  = $clog2(NUM_WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [SET_W-1:0] acc_set,
  input  logic             acc_hit,
  input  logic [WAY_W-1:0] acc_way,
  output logic             victim_valid,
  output logic [WAY_W-1:0] victim_way
);
  localparam int PAIRS  = NUM_WAYS / 2;
  localparam int PAIR_W = $clog2(PAIRS);
  localparam int NODES  = PAIRS - 1;

  logic [NODES-1:0]  cur_tree;
  logic [NODES-1:0]  new_tree;
  logic [PAIR_W-1:0] pick_pair;
  logic              rnd_bit;
  logic              is_miss;
  logic [WAY_W-1:0]  touched_way;

  assign is_miss = acc_valid & ~acc_hit;

  rpl_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk  (clk),
    .rst_n(rst_n),
    .step (is_miss),
    .rnd  (rnd_bit)
  );

  rpl_tree_store #(.NUM_SETS(NUM_SETS), .NODES(NODES)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_idx(acc_set),
    .wr_en  (acc_valid),
    .wr_tree(new_tree),
    .rd_tree(cur_tree)
  );

  rpl_path_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
    .tree(cur_tree),
    .pair(pick_pair)
  );

  assign victim_way   = {pick_pair, rnd_bit};
  assign victim_valid = is_miss;
  assign touched_way  = acc_hit ? acc_way : victim_way;

  rpl_tree_update #(.NUM_WAYS(NUM_WAYS)) u_upd (
    .tree     (cur_tree),
    .way      (touched_way),
    .tree_next(new_tree)
  );
endmodule

// File: rtl/rpl_victim_sel_chk.sv
module rpl_victim_sel_chk #(
  parameter int SET_W = 4,
  parameter int WAY_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic [SET_W-1:0] acc_set,
  input logic             acc_hit,
  input logic [WAY_W-1:0] acc_way,
  input logic             victim_valid,
  input logic [WAY_W-1:0] victim_way
);
  logic             seen;
  logic             p_acc, p_hit;
  logic [SET_W-1:0] p_set;
  logic             p_hit_top;
  logic             p_vic_top;
  logic [WAY_W-2:0] p_pair;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= 1'b0; p_acc <= 1'b0; p_hit <= 1'b0; p_set <= '0;
      p_hit_top <= 1'b0; p_vic_top <= 1'b0; p_pair <= '0;
    end else begin
      seen      <= 1'b1;
      p_acc     <= acc_valid;
      p_hit     <= acc_hit;
      p_set     <= acc_set;
      p_hit_top <= acc_way[WAY_W-1];
      p_vic_top <= victim_way[WAY_W-1];
      p_pair    <= victim_way[WAY_W-1:1];
    end
  end

  assert_victim_needs_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> (acc_valid && !acc_hit));

  assert_miss_gives_victim_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_hit) |-> victim_valid);

  assert_root_flips_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && p_acc && !p_hit && acc_valid && !acc_hit && acc_set == p_set)
      |-> (victim_way[WAY_W-1] != p_vic_top));

  assert_hit_points_away_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && p_acc && p_hit && acc_valid && !acc_hit && acc_set == p_set)
      |-> (victim_way[WAY_W-1] != p_hit_top));

  assert_idle_keeps_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !p_acc && acc_set == p_set) |-> (victim_way[WAY_W-1:1] == p_pair));

  assert_way_known_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(victim_way));
endmodule

bind rpl_victim_sel rpl_victim_sel_chk #(.SET_W(SET_W), .WAY_W(WAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
  .acc_hit(acc_hit), .acc_way(acc_way), .victim_valid(victim_valid),
  .victim_way(victim_way)
);

// File: tb/rpl_victim_sel_tb.sv
module rpl_victim_sel_tb;
  localparam int NUM_SETS = 16;
  localparam int SET_W = 4;
  localparam int WAY_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0;
  logic [SET_W-1:0] acc_set = '0;
  logic acc_hit = 1'b0;
  logic [WAY_W-1:0] acc_way = '0;
  logic victim_valid;
  logic [WAY_W-1:0] victim_way;

  always #2.5 clk = ~clk;

  rpl_victim_sel #(.NUM_SETS(NUM_SETS)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
    .acc_hit(acc_hit), .acc_way(acc_way), .victim_valid(victim_valid),
    .victim_way(victim_way)
  );

  int n_run = 0, n_fail = 0;
  int ones = 0, zeros = 0;
  bit done = 0;
  int miss_cnt [NUM_SETS];
  logic [2:0] exp_q [$];
  string tag_q [$];

  function automatic logic [2:0] br3(input int k);
    logic [2:0] v;
    v = 3'(k % 8);
    return {v[0], v[1], v[2]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // driver: miss with the pair predicted by the requirement sequence
  task automatic drive_miss(input int s, input logic [2:0] pair, input string tag);
    @(negedge clk);
    acc_valid = 1'b1; acc_hit = 1'b0; acc_set = SET_W'(s);
    exp_q.push_back(pair); tag_q.push_back(tag);
  endtask

  task automatic drive_seq_miss(input int s, input string tag);
    drive_miss(s, br3(miss_cnt[s]), tag);
    miss_cnt[s]++;
  endtask

  task automatic drive_hit(input int s, input int w);
    @(negedge clk);
    acc_valid = 1'b1; acc_hit = 1'b1; acc_set = SET_W'(s); acc_way = WAY_W'(w);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      acc_valid = 1'b0; acc_hit = 1'b0;
    end
  endtask

  // monitor: scoreboard pop on each victim
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && victim_valid) begin
        if (exp_q.size() == 0) check(0, "R2 unexpected victim", 1, 0);
        else begin
          logic [2:0] e;
          string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          check(victim_way[3:1] == e, t, int'(victim_way[3:1]), int'(e));
          if (victim_way[0]) ones++; else zeros++;
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    check(0, "watchdog", 0, 1);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NUM_SETS; s++) miss_cnt[s] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(victim_valid == 1'b0, "R2 idle no victim", int'(victim_valid), 0);
    check(victim_way[3:1] == 3'd0, "R1 reset candidate pair", int'(victim_way[3:1]), 0);

    // R1: first miss in the last set picks pair 0
    drive_seq_miss(NUM_SETS-1, "R1 first miss pair 0");
    idle(1);

    // R4 and R9: back-to-back misses follow the 8-step cycle, twice
    for (int k = 0; k < 16; k++) drive_seq_miss(3, "R4 sequence set3");
    idle(1);

    // R6: interleaving sets keeps separate sequences
    for (int k = 0; k < 8; k++) begin
      drive_seq_miss(5, "R6 interleave set5");
      drive_seq_miss(3, "R6 interleave set3");
    end
    idle(1);

    // R2: a hit raises no victim
    drive_hit(10, 6);
    #1;
    check(victim_valid == 1'b0, "R2 hit no victim", int'(victim_valid), 0);
    idle(1);

    // R5: hit then miss on fresh sets, pair = {~w[3],0,0}
    drive_hit(8, 13);
    drive_miss(8, 3'd0, "R5 hit way13 then miss");
    drive_hit(9, 2);
    drive_miss(9, 3'd4, "R5 hit way2 then miss");
    idle(1);

    // R8: idle cycles do not move the candidate of set 5
    drive_seq_miss(5, "R8 before idle");
    idle(4);
    acc_set = 4'd5;
    #1;
    check(victim_way[3:1] == br3(miss_cnt[5]), "R8 idle keeps pair",
          int'(victim_way[3:1]), int'(br3(miss_cnt[5])));
    drive_seq_miss(5, "R8 after idle");
    idle(1);

    // R7: 256 misses in one set, balance of the random bit
    ones = 0; zeros = 0;
    for (int k = 0; k < 256; k++) drive_seq_miss(2, "R7 long run pair");
    idle(2);
    check(ones >= 64, "R7 ones count", ones, 64);
    check(zeros >= 64, "R7 zeros count", zeros, 64);
    check(exp_q.size() == 0, "R3 all victims seen", exp_q.size(), 0);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule